// File: doc/BRIEF.md
# DRAM Self-Refresh Entry and Exit Sequencer

This block sits on the controller side of a double-data-rate network DRAM. It takes the memory into self-refresh and brings it back out. During both sequences it owns the command bus, the power-down pin and the enable of the memory clock gate. A host starts a sequence with a one-cycle request. Two status flags tell the host when it may issue commands again: one for ordinary commands and a separate one for reads.

Entering self-refresh works like this. The block issues a refresh command and then deselects on every slot. It lowers the power-down pin at the earliest point of the allowed window. Because a late edge would make the memory fall back to plain power-down, the block never stretches the edge toward the late end of the window. It keeps the clock alive until the minimum clock-hold count has passed, and only then gates it.

Leaving self-refresh works like this. The clock restarts first and settles for a set count. The pin then rises, and only deselects follow for the recovery time. Next comes one refresh command and its empty second slot. At that point ordinary commands are released. Reads are released only after the DLL relock count, measured from the pin rise.

Every interval is a parameter counted in clock cycles. A configuration flag reports window settings that the memory would not accept.

Top module: `sref_seq`

## Requirements
- R1: After reset the block drives deselect (command code 0) on `cmd_o`, holds `pd_o` and `clk_en_o` high, holds `cmd_ok_o` and `read_ok_o` high, and holds `busy_o` low.
- R2: A `req_enter` pulse while idle puts refresh (command code 1) on `cmd_o` in the next cycle. Every later slot carries deselect (code 0) until the exit sequence issues its own refresh.
- R3: `pd_o` falls exactly T_FPDL_MIN cycles after the cycle carrying the entry refresh, which places it inside the window [T_FPDL_MIN, T_FPDL_MAX]. `cfg_err_o` is high when T_FPDL_MIN < 1, T_FPDL_MIN > T_FPDL_MAX, T_FPDL_MAX > L_PDV, L_REFC < L_PDA or L_STAB < 1, and low otherwise.
- R4: `clk_en_o` falls max(L_CKD, T_FPDL_MIN+1) cycles after the entry refresh cycle, never before L_CKD. `busy_o` drops in that same cycle.
- R5: `cmd_ok_o` and `read_ok_o` go low in the entry refresh cycle. They stay low through self-refresh and the exit sequence until their own release points, and `cmd_ok_o` is never high while `busy_o` is high.
- R6: A `req_exit` pulse in self-refresh raises `clk_en_o` and `busy_o` in the next cycle (call it cycle 0). `pd_o` rises in cycle L_STAB, while the clock is already running.
- R7: With the pin rise in cycle p, cycles p to p+L_REFC-1 carry deselect. Cycle p+L_REFC carries refresh (code 1) and cycle p+L_REFC+1 carries deselect. In cycle p+L_REFC+2 `cmd_ok_o` rises and `busy_o` falls.
- R8: `read_ok_o` rises in cycle max(p+L_LOCK, p+L_REFC+2) and never before `cmd_ok_o`.
- R9: A `req_exit` pulse that arrives during the entry sequence is dropped. Once entry completes, `pd_o` and `clk_en_o` stay low until a new `req_exit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req_enter | input | 1 | One-cycle request to enter self-refresh |
| req_exit | input | 1 | One-cycle request to leave self-refresh |
| cmd_o | output | 3 | Command slot: 0 deselect, 1 refresh |
| pd_o | output | 1 | Power-down pin level |
| clk_en_o | output | 1 | Memory clock gate enable |
| busy_o | output | 1 | Entry or exit sequence in progress |
| cmd_ok_o | output | 1 | Host may issue non-read commands |
| read_ok_o | output | 1 | Host may issue read command pairs |
| cfg_err_o | output | 1 | Timing parameters violate the pin rules |

## Verification
The bench repeats full entry and exit cycles and varies the dwell time in self-refresh and the gap before the next entry. It checks every output in every cycle against arithmetic positions taken from the parameters, which finds an off-by-one in the pin-fall, clock-gate, refresh-slot or release cycles. Two instances share the stimulus: in one the relock time is longer than the recovery, in the other it is shorter. A design that tied the read release to the command release, or ignored either bound, fails on one of them. An exit request injected mid-entry checks that a design which latched or obeyed it early does not raise the pin or restart the clock, and the second instance carries a deliberately bad window to check the configuration flag.

// File: rtl/sref_pkg.sv
package sref_pkg;
  typedef enum logic [2:0] {
    CMD_DESL = 3'd0,
    CMD_REF  = 3'd1,
    CMD_WRA  = 3'd2,
    CMD_RDA  = 3'd3,
    CMD_LAL  = 3'd4
  } cmd_e;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_ENTER = 3'd1,
    S_SREF  = 3'd2,
    S_STAB  = 3'd3,
    S_REFC  = 3'd4,
    S_GAP   = 3'd5,
    S_FIN   = 3'd6
  } state_e;
endpackage

// File: rtl/sref_timer.sv
module sref_timer #(
  parameter int W   = 5,
  parameter int MAX = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)                 cnt <= '0;
    else if (clr)            cnt <= W'(1);
    else if (cnt != W'(MAX)) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sref_cfg_chk.sv
module sref_cfg_chk #(
  parameter int T_FPDL_MIN = 2,
  parameter int T_FPDL_MAX = 4,
  parameter int L_PDV      = 5,
  parameter int L_PDA      = 2,
  parameter int L_REFC     = 4,
  parameter int L_STAB     = 3
) (
  output logic bad
);
  // window must sit before the fallback limit; recovery must cover the pin-active interval
  assign bad = (T_FPDL_MIN < 1) || (T_FPDL_MIN > T_FPDL_MAX) ||
               (T_FPDL_MAX > L_PDV) || (L_REFC < L_PDA) || (L_STAB < 1);
endmodule

// File: rtl/sref_seq.sv
module sref_seq
  import sref_pkg::*;
#(
  parameter int T_FPDL_MIN = 2,
  parameter int T_FPDL_MAX = 4,
  parameter int L_PDV      = 5,
  parameter int L_CKD      = 4,
  parameter int L_STAB     = 3,
  parameter int L_PDA      = 2,
  parameter int L_REFC     = 4,
  parameter int L_LOCK     = 9
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_enter,
  input  logic       req_exit,
  output logic [2:0] cmd_o,
  output logic       pd_o,
  output logic       clk_en_o,
  output logic       busy_o,
  output logic       cmd_ok_o,
  output logic       read_ok_o,
  output logic       cfg_err_o
);
  localparam int CKD_AT = (L_CKD > T_FPDL_MIN) ? L_CKD : T_FPDL_MIN + 1;
  localparam int M1     = (CKD_AT > L_STAB) ? CKD_AT : L_STAB;
  localparam int M2     = (L_REFC > L_LOCK) ? L_REFC : L_LOCK;
  localparam int M3     = (T_FPDL_MAX > L_PDV) ? T_FPDL_MAX : L_PDV;
  localparam int M12    = (M1 > M2) ? M1 : M2;
  localparam int CMAX   = ((M12 > M3) ? M12 : M3) + 3;
  localparam int CW     = $clog2(CMAX + 1);

  state_e        st;
  cmd_e          cmd_q;
  logic          pd_q, clk_en_q, busy_q, cmd_ok_q, read_ok_q, err_q;
  logic          lock_wait;
  logic          cfg_bad;
  logic          adv, lk_clr;
  logic [CW-1:0] cnt, lk, ref_age;

  sref_cfg_chk #(
    .T_FPDL_MIN(T_FPDL_MIN), .T_FPDL_MAX(T_FPDL_MAX), .L_PDV(L_PDV),
    .L_PDA(L_PDA), .L_REFC(L_REFC), .L_STAB(L_STAB)
  ) i_cfg (.bad(cfg_bad));

  // phase timer restarts at 1 on every state change
  always_comb begin
    unique case (st)
      S_IDLE:  adv = req_enter;
      S_ENTER: adv = (cnt == CW'(CKD_AT));
      S_SREF:  adv = req_exit;
      S_STAB:  adv = (cnt == CW'(L_STAB));
      S_REFC:  adv = (cnt == CW'(L_REFC));
      default: adv = 1'b1;
    endcase
  end
  assign lk_clr = (st == S_STAB) && (cnt == CW'(L_STAB));

  sref_timer #(.W(CW), .MAX(CMAX)) i_phase (.clk(clk), .rst(rst), .clr(adv),    .cnt(cnt));
  sref_timer #(.W(CW), .MAX(CMAX)) i_lock  (.clk(clk), .rst(rst), .clr(lk_clr), .cnt(lk));

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      cmd_q     <= CMD_DESL;
      pd_q      <= 1'b1;
      clk_en_q  <= 1'b1;
      busy_q    <= 1'b0;
      cmd_ok_q  <= 1'b1;
      read_ok_q <= 1'b1;
      lock_wait <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      err_q <= cfg_bad;
      unique case (st)
        S_IDLE: begin
          if (req_enter) begin
            cmd_q     <= CMD_REF;
            busy_q    <= 1'b1;
            cmd_ok_q  <= 1'b0;
            read_ok_q <= 1'b0;
            st        <= S_ENTER;
          end else if (lock_wait && lk >= CW'(L_LOCK)) begin
            read_ok_q <= 1'b1;
            lock_wait <= 1'b0;
          end
        end
        S_ENTER: begin
          cmd_q <= CMD_DESL;
          if (cnt == CW'(T_FPDL_MIN)) pd_q <= 1'b0;
          if (cnt == CW'(CKD_AT)) begin
            clk_en_q <= 1'b0;
            busy_q   <= 1'b0;
            st       <= S_SREF;
          end
        end
        S_SREF: begin
          if (req_exit) begin
            clk_en_q <= 1'b1;
            busy_q   <= 1'b1;
            st       <= S_STAB;
          end
        end
        S_STAB: begin
          if (cnt == CW'(L_STAB)) begin
            pd_q      <= 1'b1;
            lock_wait <= 1'b1;
            st        <= S_REFC;
          end
        end
        S_REFC: begin
          if (cnt == CW'(L_REFC)) begin
            cmd_q <= CMD_REF;
            st    <= S_GAP;
          end
        end
        S_GAP: begin
          cmd_q <= CMD_DESL;
          st    <= S_FIN;
        end
        S_FIN: begin
          cmd_ok_q  <= 1'b1;
          busy_q    <= 1'b0;
          read_ok_q <= (lk >= CW'(L_LOCK));
          if (lk >= CW'(L_LOCK)) lock_wait <= 1'b0;
          st        <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign cmd_o     = cmd_q;
  assign pd_o      = pd_q;
  assign clk_en_o  = clk_en_q;
  assign busy_o    = busy_q;
  assign cmd_ok_o  = cmd_ok_q;
  assign read_ok_o = read_ok_q;
  assign cfg_err_o = err_q;

  // cycles since the last refresh on the bus, kept apart from the phase timer
  always_ff @(posedge clk) begin
    if (rst)                          ref_age <= CW'(CMAX);
    else if (cmd_q == CMD_REF)        ref_age <= CW'(1);
    else if (ref_age != CW'(CMAX))    ref_age <= ref_age + 1'b1;
  end

  p_desl_while_pd_low_r2: assert property (@(posedge clk) disable iff (rst)
    !pd_q |-> (cmd_q == CMD_DESL));

  p_pd_fall_window_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(pd_q) |-> (ref_age >= CW'(T_FPDL_MIN) && ref_age <= CW'(T_FPDL_MAX)));

  p_gate_after_ckd_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(clk_en_q) |-> (ref_age >= CW'(L_CKD)));

  p_busy_blocks_cmd_r5: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> !cmd_ok_q);

  p_pd_rise_clock_on_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(pd_q) |-> (clk_en_q && $past(clk_en_q)));

  p_read_after_cmd_r8: assert property (@(posedge clk) disable iff (rst)
    read_ok_q |-> cmd_ok_q);
endmodule

// File: tb/test_sref_seq.sv
module test_sref_seq;
  localparam int CLK_PERIOD = 10;
  localparam int TMIN = 2, CKD = 4, STAB = 3, REFC = 4, LOCK_A = 9, LOCK_B = 3;
  localparam int CKD_AT = (CKD > TMIN) ? CKD : TMIN + 1;
  localparam int REL    = STAB + REFC + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_enter = 1'b0;
  logic req_exit = 1'b0;
  logic [2:0] cmd_a, cmd_b;
  logic pd_a, ce_a, busy_a, cok_a, rok_a, err_a;
  logic pd_b, ce_b, busy_b, cok_b, rok_b, err_b;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sref_seq #(.T_FPDL_MIN(TMIN), .T_FPDL_MAX(4), .L_PDV(5), .L_CKD(CKD),
             .L_STAB(STAB), .L_PDA(2), .L_REFC(REFC), .L_LOCK(LOCK_A)) i_sref_seq (
    .clk(clk), .rst(rst), .req_enter(req_enter), .req_exit(req_exit),
    .cmd_o(cmd_a), .pd_o(pd_a), .clk_en_o(ce_a), .busy_o(busy_a),
    .cmd_ok_o(cok_a), .read_ok_o(rok_a), .cfg_err_o(err_a));

  sref_seq #(.T_FPDL_MIN(TMIN), .T_FPDL_MAX(6), .L_PDV(5), .L_CKD(CKD),
             .L_STAB(STAB), .L_PDA(2), .L_REFC(REFC), .L_LOCK(LOCK_B)) i_sref_seq_b (
    .clk(clk), .rst(rst), .req_enter(req_enter), .req_exit(req_exit),
    .cmd_o(cmd_b), .pd_o(pd_b), .clk_en_o(ce_b), .busy_o(busy_b),
    .cmd_ok_o(cok_b), .read_ok_o(rok_b), .cfg_err_o(err_b));

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
    end
  endtask

  // both instances share entry and command-release timing
  task automatic chk_common(input string rq, input int cmd, input int pd, input int ce,
                            input int busy, input int cok);
    chk({rq, " cmd A"}, int'(cmd_a), cmd);   chk({rq, " cmd B"}, int'(cmd_b), cmd);
    chk({rq, " pd A"}, int'(pd_a), pd);      chk({rq, " pd B"}, int'(pd_b), pd);
    chk({rq, " clk_en A"}, int'(ce_a), ce);  chk({rq, " clk_en B"}, int'(ce_b), ce);
    chk({rq, " busy A"}, int'(busy_a), busy); chk({rq, " busy B"}, int'(busy_b), busy);
    chk({rq, " cmd_ok A"}, int'(cok_a), cok); chk({rq, " cmd_ok B"}, int'(cok_b), cok);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_common("R1 reset", 0, 1, 1, 0, 1);
    chk("R1 read_ok A", int'(rok_a), 1);
    chk("R1 read_ok B", int'(rok_b), 1);
    chk("R3 cfg_err good window", int'(err_a), 0);
    chk("R3 cfg_err late window", int'(err_b), 1);

    for (int w = 0; w < 5; w++) begin
      for (int g = 0; g < 3; g++) begin
        repeat (g) @(negedge clk);
        // entry: refresh lands in cycle 0
        req_enter = 1'b1;
        @(negedge clk);
        req_enter = 1'b0;
        for (int j = 0; j <= CKD_AT + 1; j++) begin
          if (j > 0) @(negedge clk);
          chk_common("R2 R3 R4 R5 R9 entry", (j == 0) ? 1 : 0, (j < TMIN) ? 1 : 0,
                     (j < CKD_AT) ? 1 : 0, (j < CKD_AT) ? 1 : 0, 0);
          chk("R5 read_ok A entry", int'(rok_a), 0);
          chk("R5 read_ok B entry", int'(rok_b), 0);
          // an exit request mid-entry must be dropped
          req_exit = (j == 1) ? 1'b1 : 1'b0;
        end
        req_exit = 1'b0;
        for (int k = 0; k < w; k++) begin
          @(negedge clk);
          chk_common("R9 self-refresh hold", 0, 0, 0, 0, 0);
        end
        // exit: clock returns in cycle 0
        req_exit = 1'b1;
        @(negedge clk);
        req_exit = 1'b0;
        for (int j = 0; j <= STAB + LOCK_A + 2; j++) begin
          if (j > 0) @(negedge clk);
          chk_common("R6 R7 exit", (j == STAB + REFC) ? 1 : 0, (j >= STAB) ? 1 : 0, 1,
                     (j < REL) ? 1 : 0, (j >= REL) ? 1 : 0);
          chk("R8 read_ok A", int'(rok_a),
              (j >= ((STAB + LOCK_A > REL) ? STAB + LOCK_A : REL)) ? 1 : 0);
          chk("R8 read_ok B", int'(rok_b),
              (j >= ((STAB + LOCK_B > REL) ? STAB + LOCK_B : REL)) ? 1 : 0);
        end
      end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule